// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block is the device-side command interface of a parallel NOR-style flash. The chip-enable, write-enable and output-enable strobes arrive asynchronously. The block synchronises them to the system clock and turns each bus write into one captured address/data pair. A write starts when both enables are low with output-enable high. Its address is taken when the later of the two enables falls, and its data when the first of them rises. A state machine checks the stream of writes against the multi-cycle unlock command sequences.

When a sequence completes, the decoder raises a one-clock strobe for one of these operations: chip erase, sector erase, program, boot-block lockout, ID-mode entry or ID-mode exit. For program and sector erase it also presents the target address, the data and the sector class. It tracks three pieces of state:
- the ID-mode flag;
- a sticky boot-lockout flag;
- the read and standby condition of the bus.

The array, erase and program timing, and the pad drivers belong to neighbouring logic.

The state machine has seven states: `ST_IDLE`, `ST_UNLK1`, `ST_UNLK2`, `ST_PROG`, `ST_ERS1`, `ST_ERS2` and `ST_ERS3`. All transitions happen on a captured write.
- `ST_IDLE` goes to `ST_UNLK1` on AA at 5555.
- `ST_UNLK1` goes to `ST_UNLK2` on 55 at 2AAA.
- From `ST_UNLK2`, a write at 5555 selects the next step by its data:
  - A0 goes to `ST_PROG`.
  - 80 goes to `ST_ERS1`.
  - 90 enters ID mode and returns to `ST_IDLE`.
  - F0 leaves ID mode and returns to `ST_IDLE`.
- `ST_PROG` issues a program on any write and returns to `ST_IDLE`.
- `ST_ERS1` goes to `ST_ERS2` on AA at 5555.
- `ST_ERS2` goes to `ST_ERS3` on 55 at 2AAA.
- `ST_ERS3` selects the operation and returns to `ST_IDLE`:
  - 10 at 5555 is chip erase.
  - 40 at 5555 is lockout.
  - 30 at any address is sector erase.
- Any write that does not match the current stage returns the machine to `ST_IDLE`.
- Bus reset forces `ST_IDLE` from any state.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After system reset (`rst_n` low) there are no strobes and `id_mode` and `boot_locked` are 0. With `ce_n` high, `standby` is 1 and `rd_en` is 0.
- R2: A few clocks after the bus settles, `rd_en` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1. `standby` is 1 exactly when `ce_n`=1.
- R3: Each write is decoded the same way whether it is controlled by WE or by CE. Its address is the value present when the later enable falls, and its data is the value present when the first enable rises. A write made with `oe_n` low is ignored.
- R4: The writes AA@5555, 55@2AAA, A0@5555 and then D@A produce one `program_stb` with `tgt_addr`=A and `tgt_data`=D.
- R5: Command matching compares only address bits 15..0 and data bits 7..0.
- R6: The six writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555 produce `chip_erase_stb`. Chip erase is issued even when the boot block is locked.
- R7: The same six-write sequence ending in 30 at address A produces `sector_erase_stb` with `tgt_addr`=A. `tgt_sector` is 3 for 7E000–7FFFF, 2 for 7D000–7DFFF, 1 for 7C000–7CFFF and 0 for 00000–7BFFF.
- R8: The same six-write sequence ending in 40@5555 produces `lockout_stb` and sets `boot_locked`. The flag survives a bus reset and clears only on system reset.
- R9: While `boot_locked` is 1, a program or sector erase aimed at 7E000–7FFFF gives no strobe. Targets outside that range are still issued.
- R10: AA@5555, 55@2AAA, 90@5555 gives `id_enter_stb` and sets `id_mode`. There are two ways out, each giving `id_exit_stb` and clearing `id_mode`: AA@5555, 55@2AAA, F0@5555, or a single F0 write at any address while in ID mode. A single F0 write outside ID mode does nothing.
- R11: A write that does not match the current stage abandons the sequence. A later continuation of that sequence therefore gives no strobe.
- R12: `bus_rst_n` low returns the decoder to idle and clears `id_mode`.
- R13: At most one strobe is high in any clock, and each completed command gives exactly one one-clock strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low, clears all state |
| bus_rst_n | input | 1 | Bus reset, active low, asynchronous, synchronised inside |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Bus address |
| dq_in | input | DATA_W | Bus write data |
| rd_en | output | 1 | Read condition: drive outputs |
| standby | output | 1 | Chip deselected |
| chip_erase_stb | output | 1 | Chip erase command strobe |
| sector_erase_stb | output | 1 | Sector erase command strobe |
| program_stb | output | 1 | Program command strobe |
| lockout_stb | output | 1 | Boot lockout command strobe |
| id_enter_stb | output | 1 | ID mode entry strobe |
| id_exit_stb | output | 1 | ID mode exit strobe |
| tgt_addr | output | ADDR_W | Target address of last program or sector erase |
| tgt_data | output | DATA_W | Data of last program or sector erase write |
| tgt_sector | output | 2 | Sector class of tgt_addr (R7 encoding) |
| id_mode | output | 1 | ID mode active |
| boot_locked | output | 1 | Sticky boot lockout flag |

## Verification
The bench targets the capture edges with CE-controlled writes in which the address and data change between the two enable edges. A decoder that latched on the wrong edge would report the decoy address or data. Sequences are broken at the third and at the fifth write and then continued. A design that did not return to idle would fire a program or erase that the scoreboard does not expect. Further cases cover: high address and data bits set on command cycles, locked boot-range targets next to unlocked ones, and a bus reset in the middle of a sequence and while the lockout flag is set. These catch a compare that is too wide, a guard on the wrong range, and a lockout flag that is cleared by the wrong reset.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_UNLK1 = 3'd1,
        ST_UNLK2 = 3'd2,
        ST_PROG  = 3'd3,
        ST_ERS1  = 3'd4,
        ST_ERS2  = 3'd5,
        ST_ERS3  = 3'd6
    } cmd_state_e;

    typedef enum logic [1:0] {
        SEC_MAIN = 2'd0,
        SEC_PAR2 = 2'd1,
        SEC_PAR1 = 2'd2,
        SEC_BOOT = 2'd3
    } sector_e;

    localparam int CMP_AW = 16;
    localparam int CMP_DW = 8;

    localparam logic [CMP_AW-1:0] KEY_ADDR_A = 16'h5555;
    localparam logic [CMP_AW-1:0] KEY_ADDR_B = 16'h2AAA;

    localparam logic [CMP_DW-1:0] OP_KEY_A   = 8'hAA;
    localparam logic [CMP_DW-1:0] OP_KEY_B   = 8'h55;
    localparam logic [CMP_DW-1:0] OP_PROGRAM = 8'hA0;
    localparam logic [CMP_DW-1:0] OP_ERASE   = 8'h80;
    localparam logic [CMP_DW-1:0] OP_CHIP    = 8'h10;
    localparam logic [CMP_DW-1:0] OP_SECTOR  = 8'h30;
    localparam logic [CMP_DW-1:0] OP_LOCK    = 8'h40;
    localparam logic [CMP_DW-1:0] OP_ID_IN   = 8'h90;
    localparam logic [CMP_DW-1:0] OP_ID_OUT  = 8'hF0;

endpackage

// File: rtl/flash_sync.sv
module flash_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/flash_wr_capture.sv
module flash_wr_capture #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n_s,
    input  logic              we_n_s,
    input  logic              oe_n_s,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic both_low;
    logic both_low_q;
    logic armed;

    assign both_low = !ce_n_s && !we_n_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            both_low_q <= 1'b0;
            armed      <= 1'b0;
            wr_valid   <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
        end else begin
            both_low_q <= both_low;
            wr_valid   <= 1'b0;
            if (both_low && !both_low_q) begin
                // later falling enable: take address
                armed   <= oe_n_s;
                wr_addr <= addr;
            end else if (!both_low && both_low_q) begin
                // first rising enable: take data
                if (armed) begin
                    wr_valid <= 1'b1;
                    wr_data  <= dq_in;
                end
                armed <= 1'b0;
            end else if (both_low && !oe_n_s) begin
                armed <= 1'b0;
            end
        end
    end

    // R3
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R3
    wr_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !$past(both_low) && $past(both_low_q));

endmodule

// File: rtl/flash_sector_map.sv
module flash_sector_map
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W      = 19,
    parameter int unsigned BOOT_WORDS  = 8192,
    parameter int unsigned PARAM_WORDS = 4096,
    parameter bit          TOP_BOOT    = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output sector_e           sector
);
    localparam longint DEPTH = longint'(1) << ADDR_W;

    if (TOP_BOOT) begin : g_top
        localparam logic [ADDR_W-1:0] BOOT_LO = ADDR_W'(DEPTH - longint'(BOOT_WORDS));
        localparam logic [ADDR_W-1:0] PAR1_LO = ADDR_W'(DEPTH - longint'(BOOT_WORDS) - longint'(PARAM_WORDS));
        localparam logic [ADDR_W-1:0] PAR2_LO = ADDR_W'(DEPTH - longint'(BOOT_WORDS) - 2 * longint'(PARAM_WORDS));
        always_comb begin
            if (addr >= BOOT_LO)      sector = SEC_BOOT;
            else if (addr >= PAR1_LO) sector = SEC_PAR1;
            else if (addr >= PAR2_LO) sector = SEC_PAR2;
            else                      sector = SEC_MAIN;
        end
    end else begin : g_bottom
        localparam logic [ADDR_W-1:0] BOOT_END = ADDR_W'(longint'(BOOT_WORDS));
        localparam logic [ADDR_W-1:0] PAR1_END = ADDR_W'(longint'(BOOT_WORDS) + longint'(PARAM_WORDS));
        localparam logic [ADDR_W-1:0] PAR2_END = ADDR_W'(longint'(BOOT_WORDS) + 2 * longint'(PARAM_WORDS));
        always_comb begin
            if (addr < BOOT_END)      sector = SEC_BOOT;
            else if (addr < PAR1_END) sector = SEC_PAR1;
            else if (addr < PAR2_END) sector = SEC_PAR2;
            else                      sector = SEC_MAIN;
        end
    end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst_n_s,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  sector_e           wr_sector,
    output logic              chip_erase_stb,
    output logic              sector_erase_stb,
    output logic              program_stb,
    output logic              lockout_stb,
    output logic              id_enter_stb,
    output logic              id_exit_stb,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_data,
    output sector_e           tgt_sector,
    output logic              id_mode,
    output logic              boot_locked
);
    cmd_state_e state, nxt_state;

    logic            hit_a, hit_b, boot_hit;
    logic [CMP_DW-1:0] op;
    logic f_chip, f_sect, f_prog, f_lock, f_idin, f_idout;

    assign hit_a    = wr_addr[CMP_AW-1:0] == KEY_ADDR_A;
    assign hit_b    = wr_addr[CMP_AW-1:0] == KEY_ADDR_B;
    assign op       = wr_data[CMP_DW-1:0];
    assign boot_hit = boot_locked && (wr_sector == SEC_BOOT);

    always_comb begin
        nxt_state = state;
        f_chip  = 1'b0;
        f_sect  = 1'b0;
        f_prog  = 1'b0;
        f_lock  = 1'b0;
        f_idin  = 1'b0;
        f_idout = 1'b0;
        if (!bus_rst_n_s) begin
            nxt_state = ST_IDLE;
        end else if (wr_valid) begin
            if (id_mode && op == OP_ID_OUT && state != ST_PROG) begin
                f_idout   = 1'b1;
                nxt_state = ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (hit_a && op == OP_KEY_A) nxt_state = ST_UNLK1;
                    end
                    ST_UNLK1: begin
                        nxt_state = (hit_b && op == OP_KEY_B) ? ST_UNLK2 : ST_IDLE;
                    end
                    ST_UNLK2: begin
                        nxt_state = ST_IDLE;
                        if (hit_a) begin
                            if (op == OP_PROGRAM)     nxt_state = ST_PROG;
                            else if (op == OP_ERASE)  nxt_state = ST_ERS1;
                            else if (op == OP_ID_IN)  f_idin    = 1'b1;
                            else if (op == OP_ID_OUT) f_idout   = 1'b1;
                        end
                    end
                    ST_PROG: begin
                        nxt_state = ST_IDLE;
                        f_prog    = !boot_hit;
                    end
                    ST_ERS1: begin
                        nxt_state = (hit_a && op == OP_KEY_A) ? ST_ERS2 : ST_IDLE;
                    end
                    ST_ERS2: begin
                        nxt_state = (hit_b && op == OP_KEY_B) ? ST_ERS3 : ST_IDLE;
                    end
                    ST_ERS3: begin
                        nxt_state = ST_IDLE;
                        if (hit_a && op == OP_CHIP)      f_chip = 1'b1;
                        else if (hit_a && op == OP_LOCK) f_lock = 1'b1;
                        else if (op == OP_SECTOR)        f_sect = !boot_hit;
                    end
                    default: nxt_state = ST_IDLE;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chip_erase_stb   <= 1'b0;
            sector_erase_stb <= 1'b0;
            program_stb      <= 1'b0;
            lockout_stb      <= 1'b0;
            id_enter_stb     <= 1'b0;
            id_exit_stb      <= 1'b0;
            tgt_addr         <= '0;
            tgt_data         <= '0;
            tgt_sector       <= SEC_MAIN;
            id_mode          <= 1'b0;
            boot_locked      <= 1'b0;
        end else begin
            chip_erase_stb   <= f_chip;
            sector_erase_stb <= f_sect;
            program_stb      <= f_prog;
            lockout_stb      <= f_lock;
            id_enter_stb     <= f_idin;
            id_exit_stb      <= f_idout;
            if (f_prog || f_sect) begin
                tgt_addr   <= wr_addr;
                tgt_data   <= wr_data;
                tgt_sector <= wr_sector;
            end
            if (!bus_rst_n_s)  id_mode <= 1'b0;
            else if (f_idin)   id_mode <= 1'b1;
            else if (f_idout)  id_mode <= 1'b0;
            if (f_lock) boot_locked <= 1'b1;
        end
    end

    // R13
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chip_erase_stb, sector_erase_stb, program_stb,
                  lockout_stb, id_enter_stb, id_exit_stb}));

    // R8
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_locked |=> boot_locked);

    // R9
    boot_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (program_stb || sector_erase_stb) |-> !(boot_locked && tgt_sector == SEC_BOOT));

    // R10
    id_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_enter_stb |-> id_mode);

    // R12
    bus_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rst_n_s |=> (state == ST_IDLE && !id_mode));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W      = 19,
    parameter int          DATA_W      = 16,
    parameter int          SYNC_STAGES = 2,
    parameter int unsigned BOOT_WORDS  = 8192,
    parameter int unsigned PARAM_WORDS = 4096,
    parameter bit          TOP_BOOT    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_en,
    output logic              standby,
    output logic              chip_erase_stb,
    output logic              sector_erase_stb,
    output logic              program_stb,
    output logic              lockout_stb,
    output logic              id_enter_stb,
    output logic              id_exit_stb,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_data,
    output logic [1:0]        tgt_sector,
    output logic              id_mode,
    output logic              boot_locked
);
    localparam int NCTL = 4;

    logic [NCTL-1:0] ctl_s;
    logic bus_rst_n_s, ce_n_s, we_n_s, oe_n_s;
    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    sector_e           wr_sector;
    sector_e           tgt_sector_e;

    flash_sync #(.W(NCTL), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   ({bus_rst_n, ce_n, we_n, oe_n}),
        .q   (ctl_s)
    );

    assign {bus_rst_n_s, ce_n_s, we_n_s, oe_n_s} = ctl_s;

    assign rd_en   = !ce_n_s && !oe_n_s && we_n_s;
    assign standby = ce_n_s;

    flash_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n_s   (ce_n_s),
        .we_n_s   (we_n_s),
        .oe_n_s   (oe_n_s),
        .addr     (addr),
        .dq_in    (dq_in),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    flash_sector_map #(
        .ADDR_W(ADDR_W), .BOOT_WORDS(BOOT_WORDS),
        .PARAM_WORDS(PARAM_WORDS), .TOP_BOOT(TOP_BOOT)
    ) u_map (
        .addr   (wr_addr),
        .sector (wr_sector)
    );

    flash_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .bus_rst_n_s      (bus_rst_n_s),
        .wr_valid         (wr_valid),
        .wr_addr          (wr_addr),
        .wr_data          (wr_data),
        .wr_sector        (wr_sector),
        .chip_erase_stb   (chip_erase_stb),
        .sector_erase_stb (sector_erase_stb),
        .program_stb      (program_stb),
        .lockout_stb      (lockout_stb),
        .id_enter_stb     (id_enter_stb),
        .id_exit_stb      (id_exit_stb),
        .tgt_addr         (tgt_addr),
        .tgt_data         (tgt_data),
        .tgt_sector       (tgt_sector_e),
        .id_mode          (id_mode),
        .boot_locked      (boot_locked)
    );

    assign tgt_sector = tgt_sector_e;

    // R2
    read_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !standby);

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb_top;

    localparam int AW = 19;
    localparam int DW = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, bus_rst_n, ce_n, we_n, oe_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] dq;
    logic rd_en, standby, chip_erase_stb, sector_erase_stb, program_stb;
    logic lockout_stb, id_enter_stb, id_exit_stb, id_mode, boot_locked;
    logic [AW-1:0] tgt_addr;
    logic [DW-1:0] tgt_data;
    logic [1:0]    tgt_sector;

    flash_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq),
        .rd_en(rd_en), .standby(standby),
        .chip_erase_stb(chip_erase_stb), .sector_erase_stb(sector_erase_stb),
        .program_stb(program_stb), .lockout_stb(lockout_stb),
        .id_enter_stb(id_enter_stb), .id_exit_stb(id_exit_stb),
        .tgt_addr(tgt_addr), .tgt_data(tgt_data), .tgt_sector(tgt_sector),
        .id_mode(id_mode), .boot_locked(boot_locked)
    );

    // strobe bit index: {chip,sect,prog,lock,idin,idout}
    localparam int K_IDOUT = 0, K_IDIN = 1, K_LOCK = 2, K_PROG = 3, K_SECT = 4, K_CHIP = 5;

    typedef struct {
        int            kind;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [1:0]    sec;
        string         req;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int failures = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_op(input int kind, input logic [AW-1:0] a,
                             input logic [DW-1:0] d, input logic [1:0] sec, input string req);
        exp_t e;
        e.kind = kind; e.a = a; e.d = d; e.sec = sec; e.req = req;
        exp_q.push_back(e);
    endtask

    // WE-controlled write
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; dq = d; oe_n = 1'b1;
        ce_n = 1'b0; idle(3);
        we_n = 1'b0; idle(4);
        we_n = 1'b1; idle(4);
        ce_n = 1'b1; idle(4);
    endtask

    // CE-controlled write with decoy address before the later fall
    // and decoy data after the first rise
    task automatic wr_ce_decoy(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        oe_n = 1'b1; addr = ~a; dq = ~d;
        we_n = 1'b0; idle(4);
        addr = a; idle(2);
        ce_n = 1'b0; idle(2);
        dq = d; idle(3);
        ce_n = 1'b1; idle(4);
        addr = ~a; dq = ~d; idle(2);
        we_n = 1'b1; idle(4);
    endtask

    task automatic wr_oe_low(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; dq = d; oe_n = 1'b0;
        ce_n = 1'b0; idle(3);
        we_n = 1'b0; idle(4);
        we_n = 1'b1; idle(4);
        ce_n = 1'b1; oe_n = 1'b1; idle(4);
    endtask

    task automatic unlock();
        wr(19'h05555, 16'h00AA);
        wr(19'h02AAA, 16'h0055);
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
        unlock();
        wr(19'h05555, 16'h00A0);
        wr(a, d);
    endtask

    task automatic erase6(input logic [AW-1:0] a, input logic [7:0] code);
        unlock();
        wr(19'h05555, 16'h0080);
        unlock();
        wr(a, {8'h00, code});
    endtask

    task automatic drain(input string req);
        idle(12);
        check(exp_q.size() == 0, req, "pending strobes", exp_q.size(), 0);
    endtask

    task automatic bus_reset();
        @(negedge clk); bus_rst_n = 1'b0; idle(6);
        bus_rst_n = 1'b1; idle(6);
    endtask

    // scoreboard monitor
    logic [5:0] stb_vec;
    assign stb_vec = {chip_erase_stb, sector_erase_stb, program_stb,
                      lockout_stb, id_enter_stb, id_exit_stb};

    always @(negedge clk) begin
        if (rst_n && stb_vec != 6'd0) begin
            check($onehot(stb_vec), "R13", "strobes not onehot", stb_vec, 0);
            if (exp_q.size() == 0) begin
                check(1'b0, "R13", "unexpected strobe", stb_vec, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(stb_vec == (6'd1 << e.kind), e.req, "strobe kind", stb_vec, 6'd1 << e.kind);
                if (e.kind == K_PROG) begin
                    check(tgt_addr == e.a, e.req, "program addr", tgt_addr, e.a);
                    check(tgt_data == e.d, e.req, "program data", tgt_data, e.d);
                end
                if (e.kind == K_SECT) begin
                    check(tgt_addr == e.a, e.req, "sector addr", tgt_addr, e.a);
                    check(tgt_sector == e.sec, e.req, "sector class", tgt_sector, e.sec);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_rst_n = 1'b1; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        addr = '0; dq = '0;
        idle(4);
        rst_n = 1'b1;
        idle(4);

        // R1 reset state
        check(stb_vec == 0, "R1", "strobes after reset", stb_vec, 0);
        check(!id_mode, "R1", "id_mode after reset", id_mode, 0);
        check(!boot_locked, "R1", "lock after reset", boot_locked, 0);
        check(standby && !rd_en, "R1", "standby/rd_en after reset", {standby, rd_en}, 2'b10);

        // R2 read condition
        ce_n = 1'b0; oe_n = 1'b0; idle(4);
        check(rd_en && !standby, "R2", "read cond", {rd_en, standby}, 2'b10);
        oe_n = 1'b1; idle(4);
        check(!rd_en, "R2", "oe high blocks read", rd_en, 0);
        oe_n = 1'b0; we_n = 1'b0; idle(4);
        check(!rd_en, "R2", "we low blocks read", rd_en, 0);
        we_n = 1'b1; ce_n = 1'b1; idle(4);
        check(!rd_en && standby, "R2", "deselect", {rd_en, standby}, 2'b01);
        oe_n = 1'b1; idle(2);

        // R4 program, WE-controlled
        expect_op(K_PROG, 19'h12345, 16'h1234, 2'd0, "R4");
        prog(19'h12345, 16'h1234);
        drain("R4");

        // R3 CE-controlled with decoys on every cycle
        expect_op(K_PROG, 19'h03C3C, 16'hA5C3, 2'd0, "R3");
        wr_ce_decoy(19'h05555, 16'h00AA);
        wr_ce_decoy(19'h02AAA, 16'h0055);
        wr_ce_decoy(19'h05555, 16'h00A0);
        wr_ce_decoy(19'h03C3C, 16'hA5C3);
        drain("R3");

        // R3 write with oe low is ignored: sequence never starts
        wr_oe_low(19'h05555, 16'h00AA);
        wr(19'h02AAA, 16'h0055);
        wr(19'h05555, 16'h00A0);
        wr(19'h00100, 16'h7777);
        drain("R3");

        // R5 upper address and data bits ignored on command cycles
        expect_op(K_PROG, 19'h00ABC, 16'hBEEF, 2'd0, "R5");
        wr(19'h35555, 16'hC3AA);
        wr(19'h52AAA, 16'h1255);
        wr(19'h45555, 16'hEEA0);
        wr(19'h00ABC, 16'hBEEF);
        drain("R5");

        // R6 chip erase
        expect_op(K_CHIP, '0, '0, 2'd0, "R6");
        erase6(19'h05555, 8'h10);
        drain("R6");

        // R7 sector erase classes
        expect_op(K_SECT, 19'h7D123, '0, 2'd2, "R7");
        erase6(19'h7D123, 8'h30);
        expect_op(K_SECT, 19'h7C000, '0, 2'd1, "R7");
        erase6(19'h7C000, 8'h30);
        expect_op(K_SECT, 19'h7E800, '0, 2'd3, "R7");
        erase6(19'h7E800, 8'h30);
        expect_op(K_SECT, 19'h7BFFF, '0, 2'd0, "R7");
        erase6(19'h7BFFF, 8'h30);
        drain("R7");

        // R11 abandon at third write, then continuation
        unlock();
        wr(19'h05555, 16'h0077);
        wr(19'h05555, 16'h00A0);
        wr(19'h00020, 16'h5A5A);
        drain("R11");
        // R11 abandon at fifth write
        unlock();
        wr(19'h05555, 16'h0080);
        wr(19'h05555, 16'h00AA);
        wr(19'h02AAA, 16'h0099);
        wr(19'h02AAA, 16'h0055);
        wr(19'h7D000, 16'h0030);
        drain("R11");

        // R10 single F0 outside ID mode does nothing
        wr(19'h00000, 16'h00F0);
        drain("R10");
        // R10 entry and single-write exit
        expect_op(K_IDIN, '0, '0, 2'd0, "R10");
        unlock(); wr(19'h05555, 16'h0090);
        drain("R10");
        check(id_mode, "R10", "id_mode set", id_mode, 1);
        expect_op(K_IDOUT, '0, '0, 2'd0, "R10");
        wr(19'h01234, 16'h00F0);
        drain("R10");
        check(!id_mode, "R10", "id_mode cleared single", id_mode, 0);
        // R10 entry and three-write exit
        expect_op(K_IDIN, '0, '0, 2'd0, "R10");
        unlock(); wr(19'h05555, 16'h0090);
        expect_op(K_IDOUT, '0, '0, 2'd0, "R10");
        unlock(); wr(19'h05555, 16'h00F0);
        drain("R10");
        check(!id_mode, "R10", "id_mode cleared seq", id_mode, 0);

        // R12 bus reset clears ID mode and a partial sequence
        expect_op(K_IDIN, '0, '0, 2'd0, "R12");
        unlock(); wr(19'h05555, 16'h0090);
        drain("R12");
        bus_reset();
        check(!id_mode, "R12", "id_mode after bus reset", id_mode, 0);
        unlock();
        bus_reset();
        wr(19'h05555, 16'h00A0);
        wr(19'h00200, 16'h1111);
        drain("R12");

        // R8 lockout
        expect_op(K_LOCK, '0, '0, 2'd0, "R8");
        erase6(19'h05555, 8'h40);
        drain("R8");
        check(boot_locked, "R8", "lock set", boot_locked, 1);
        bus_reset();
        check(boot_locked, "R8", "lock kept over bus reset", boot_locked, 1);

        // R9 boot targets suppressed, others issued
        prog(19'h7F000, 16'hDEAD);
        erase6(19'h7E000, 8'h30);
        drain("R9");
        expect_op(K_PROG, 19'h00100, 16'h4321, 2'd0, "R9");
        prog(19'h00100, 16'h4321);
        expect_op(K_SECT, 19'h7D000, '0, 2'd2, "R9");
        erase6(19'h7D000, 8'h30);
        expect_op(K_CHIP, '0, '0, 2'd0, "R6");
        erase6(19'h05555, 8'h10);
        drain("R9");

        // R1 system reset clears lock
        @(negedge clk); rst_n = 1'b0; idle(3); rst_n = 1'b1; idle(4);
        check(!boot_locked, "R1", "lock cleared by system reset", boot_locked, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule